// File: doc/BRIEF.md
# PCI Function Configuration Header Register File

This block stores the 64-byte standard configuration header of a single PCI function. A configuration access port writes to it with a byte offset, a size code and up to four data bytes. A combinational read port returns any aligned dword. Each byte has its own write rule, and the rule depends on which header layout the function presents: an ordinary endpoint or a bridge. The identity fields cannot be changed. The status register clears a bit when 1 is written to it. The base address registers (BARs) go through a separate path that forces the size-aligned address bits to zero and keeps the type bits.

Device events set status bits through a separate set vector. Whenever a write touches the command register, the block pulses an output for one cycle so that address decode elsewhere can be re-evaluated. Identity values, BAR sizes and kinds, the expansion ROM size and the status bit classes are all parameters.

Top module: `cfg_hdr_file`

## Requirements
- R1: Reset loads the following values:
  - vendor id at bytes 0x00–0x01 and device id at 0x02–0x03;
  - revision at 0x08 and class code at 0x09–0x0B;
  - header type at 0x0E and interrupt pin at 0x3D;
  - the fixed status bits at 0x06–0x07;
  - value 1 in bit 0 of each implemented I/O BAR.

  Every other byte, including the command register at 0x04–0x05, resets to zero.
- R2: When the header type byte at 0x0E is 0x00 or 0x80 (ordinary layout), byte-path writes have no effect on bytes 0x00–0x03, 0x08–0x0B, 0x0E, 0x10–0x27, 0x2C–0x33 and 0x3D.
- R3: Any other header type value selects the bridge layout. In that layout, byte-path writes have no effect on bytes 0x00–0x03, 0x08–0x0B, 0x0E, 0x10–0x17, 0x38–0x3B and 0x3D. All remaining bytes, including 0x18–0x37, can be written.
- R4: The size code sets how many bytes a write carries: 0 means one byte, 1 means two, 2 means four, and 3 means none.
  - Data byte k, taken from bits 8k+7:8k, goes to offset wr_addr+k.
  - Bytes that would fall past offset 0x3F are dropped.
  - Writes take effect at the next clock edge.
- R5: Only the status bits selected by the clearable mask can change.
  - Writing a 1 to such a bit at byte 0x06 or 0x07 clears it, and writing a 0 leaves it unchanged.
  - A 1 on status_set sets the bit.
  - If a set and a clear hit the same bit in the same cycle, the set wins.
- R6: Status bits outside the clearable mask always read as their fixed parameter value, whatever is written to them.
- R7: A size-code-2 write whose wr_addr equals the base of an implemented BAR stores the written value with the address bits below the region size forced to zero.
  - For an I/O BAR, bit 0 reads 1.
  - For a memory BAR, bits 3:0 read 0.
  - Writes to BAR bytes that use any other size or alignment have no effect.

  The ordinary layout has BAR slots at 0x10, 0x14, …, 0x24. The bridge layout has slots only at 0x10 and 0x14.
- R8: A BAR slot whose size parameter is 0 always reads as zero.
- R9: The expansion ROM BAR is at 0x30 in the ordinary layout and at 0x38 in the bridge layout. A size-code-2 write at that base forces the bits below the ROM size to zero, except bit 0, the enable bit, which takes the written value.
- R10: remap_pulse is high for exactly the one cycle that follows a write clock edge at which at least one byte of the write landed on offset 0x04 or 0x05. Other writes leave it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request, sampled at the rising edge |
| wr_addr | input | 6 | Byte offset of the first written byte |
| wr_size | input | 2 | Size code: 0=1 byte, 1=2 bytes, 2=4 bytes, 3=no bytes |
| wr_data | input | 32 | Write data; byte k goes to wr_addr+k |
| status_set | input | 16 | Device event bits that set clearable status bits |
| rd_addr | input | 4 | Dword index to read |
| rd_data | output | 32 | Dword at rd_addr; the lowest offset is in bits 7:0 |
| remap_pulse | output | 1 | One-cycle pulse after a write that touched the command register |

## Verification
If the per-byte rule is wrong, or the layout is decoded wrongly from the header type byte, a protected byte changes or a writable byte keeps its old value. Either error shows up on rd_data in the very cycle after the write edge. A BAR masking error appears on the same read as nonzero bits below the region size or as a wrong type nibble. A status error appears as a bit that is set without a set event, as a set lost to a simultaneous clear, or as a fixed bit that has moved. A fault in the command-touch detection shows up as a missing or extra remap_pulse, exactly one cycle after the edge that captured the write.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int HDR_BYTES   = 64;
    localparam int HDR_DWORDS  = HDR_BYTES / 4;
    localparam int NUM_BARS    = 6;
    localparam int BRIDGE_BARS = 2;
    localparam int NUM_SLOTS   = NUM_BARS + 1;   // last slot is the expansion ROM
    localparam int BAR_FIRST   = 16;             // byte offset of the first BAR

    typedef enum logic [1:0] {
        ACC_RO  = 2'd0,
        ACC_RW  = 2'd1,
        ACC_W1C = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        BK_IO  = 2'd0,
        BK_MEM = 2'd1,
        BK_ROM = 2'd2
    } bar_kind_e;

    typedef logic [HDR_BYTES-1:0][7:0] hdr_img_t;

    function automatic logic layout_is_bridge(input logic [7:0] hdr_type);
        return !(hdr_type == 8'h00 || hdr_type == 8'h80);
    endfunction

    function automatic logic [2:0] size_to_count(input logic [1:0] code);
        logic [2:0] n;
        unique case (code)
            2'd0:    n = 3'd1;
            2'd1:    n = 3'd2;
            2'd2:    n = 3'd4;
            default: n = 3'd0;
        endcase
        return n;
    endfunction

    // Per-byte write rule for the generic byte path.
    function automatic acc_e byte_access(input logic [5:0] off, input logic bridge);
        int o;
        acc_e a;
        o = int'(off);
        a = ACC_RW;
        if (o == 6 || o == 7)
            a = ACC_W1C;
        else if (o <= 3 || (o >= 8 && o <= 11) || o == 14 || o == 61)
            a = ACC_RO;
        else if (!bridge && ((o >= 16 && o <= 39) || (o >= 44 && o <= 51)))
            a = ACC_RO;
        else if (bridge && ((o >= 16 && o <= 23) || (o >= 56 && o <= 59)))
            a = ACC_RO;
        return a;
    endfunction

endpackage

// File: rtl/cfg_hdr_lanes.sv
module cfg_hdr_lanes
    import cfg_hdr_pkg::*;
(
    input  logic                      wr_en,
    input  logic [5:0]                wr_addr,
    input  logic [1:0]                wr_size,
    input  logic [31:0]               wr_data,
    output logic [HDR_BYTES-1:0]      byte_hit,
    output logic [HDR_BYTES-1:0][7:0] byte_val
);

    logic [2:0] count;
    assign count = size_to_count(wr_size);

    for (genvar i = 0; i < HDR_BYTES; i++) begin : g_byte
        logic [6:0] rel;
        assign rel = 7'(i) - {1'b0, wr_addr};
        assign byte_hit[i] = wr_en && (7'(i) >= {1'b0, wr_addr}) && (rel < {4'b0, count});
        assign byte_val[i] = wr_data[8*rel[1:0] +: 8];
    end

endmodule

// File: rtl/cfg_hdr_bar.sv
module cfg_hdr_bar
    import cfg_hdr_pkg::*;
#(
    parameter logic [31:0] SIZE = 32'h0,
    parameter bar_kind_e   KIND = BK_MEM
) (
    input  logic [31:0] wdata,
    output logic [31:0] value
);

    localparam logic [31:0] AMASK = ~(SIZE - 32'h1);

    if (KIND == BK_IO) begin : g_io
        assign value = (wdata & AMASK & ~32'h1) | 32'h1;
    end else if (KIND == BK_MEM) begin : g_mem
        assign value = wdata & AMASK & ~32'hF;
    end else begin : g_rom
        assign value = (wdata & AMASK & ~32'h1) | {31'b0, wdata[0]};
    end

endmodule

// File: rtl/cfg_hdr_file.sv
module cfg_hdr_file
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0]             VENDOR_ID    = 16'hA5C3,
    parameter logic [15:0]             DEVICE_ID    = 16'h7E21,
    parameter logic [7:0]              REVISION     = 8'h04,
    parameter logic [23:0]             CLASS_CODE   = 24'h020000,
    parameter logic [7:0]              HDR_TYPE     = 8'h00,
    parameter logic [7:0]              INT_PIN      = 8'h01,
    parameter logic [15:0]             STS_W1C_MASK = 16'hF900,
    parameter logic [15:0]             STS_FIXED    = 16'h0010,
    parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE   = {32'h0, 32'h0, 32'h0, 32'h0, 32'h1000, 32'h20},
    parameter logic [NUM_BARS-1:0]     BAR_IS_IO    = 6'b000001,
    parameter logic [31:0]             ROM_SIZE     = 32'h800
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [5:0]  wr_addr,
    input  logic [1:0]  wr_size,
    input  logic [31:0] wr_data,
    input  logic [15:0] status_set,
    input  logic [3:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        remap_pulse
);

    localparam logic RST_BRIDGE = layout_is_bridge(HDR_TYPE);
    localparam logic [15:0] STS_KEEP = STS_FIXED & ~STS_W1C_MASK;

    function automatic hdr_img_t reset_image();
        hdr_img_t img;
        img = '0;
        img[0]  = VENDOR_ID[7:0];
        img[1]  = VENDOR_ID[15:8];
        img[2]  = DEVICE_ID[7:0];
        img[3]  = DEVICE_ID[15:8];
        img[6]  = STS_KEEP[7:0];
        img[7]  = STS_KEEP[15:8];
        img[8]  = REVISION;
        img[9]  = CLASS_CODE[7:0];
        img[10] = CLASS_CODE[15:8];
        img[11] = CLASS_CODE[23:16];
        img[14] = HDR_TYPE;
        img[61] = INT_PIN;
        for (int j = 0; j < NUM_BARS; j++) begin
            if (BAR_SIZE[j] != 32'h0 && BAR_IS_IO[j] && (!RST_BRIDGE || j < BRIDGE_BARS))
                img[BAR_FIRST + 4*j] = 8'h01;
        end
        return img;
    endfunction

    localparam hdr_img_t RST_IMG = reset_image();

    hdr_img_t hdr_q;
    hdr_img_t hdr_d;
    logic     remap_q;
    logic     bridge;

    logic [HDR_BYTES-1:0]      byte_hit;
    logic [HDR_BYTES-1:0][7:0] byte_val;
    acc_e                      acc [HDR_BYTES];

    logic [NUM_SLOTS-1:0]       bar_wr;
    logic [NUM_SLOTS-1:0][5:0]  bar_base;
    logic [NUM_SLOTS-1:0][31:0] bar_val;

    logic [15:0] sts_q;
    logic [15:0] sts_clr;
    logic [15:0] sts_n;

    assign bridge = layout_is_bridge(hdr_q[14]);

    cfg_hdr_lanes u_lanes (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_size  (wr_size),
        .wr_data  (wr_data),
        .byte_hit (byte_hit),
        .byte_val (byte_val)
    );

    for (genvar i = 0; i < HDR_BYTES; i++) begin : g_acc
        assign acc[i] = byte_access(6'(i), bridge);
    end

    for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_slot
        logic active;
        if (j < NUM_BARS) begin : g_bar
            localparam bar_kind_e K = BAR_IS_IO[j] ? BK_IO : BK_MEM;
            assign bar_base[j] = 6'(BAR_FIRST + 4*j);
            assign active = (BAR_SIZE[j] != 32'h0) && (!bridge || j < BRIDGE_BARS);
            cfg_hdr_bar #(.SIZE(BAR_SIZE[j]), .KIND(K)) u_bar (
                .wdata (wr_data),
                .value (bar_val[j])
            );
        end else begin : g_rom
            assign bar_base[j] = bridge ? 6'h38 : 6'h30;
            assign active = (ROM_SIZE != 32'h0);
            cfg_hdr_bar #(.SIZE(ROM_SIZE), .KIND(BK_ROM)) u_bar (
                .wdata (wr_data),
                .value (bar_val[j])
            );
        end
        assign bar_wr[j] = active && wr_en && (wr_size == 2'd2) && (wr_addr == bar_base[j]);
    end

    assign sts_q   = {hdr_q[7], hdr_q[6]};
    assign sts_clr = {byte_hit[7] ? byte_val[7] : 8'h00,
                      byte_hit[6] ? byte_val[6] : 8'h00};
    assign sts_n   = (((sts_q & ~sts_clr) | status_set) & STS_W1C_MASK) | STS_KEEP;

    always_comb begin
        hdr_d = hdr_q;
        for (int i = 0; i < HDR_BYTES; i++) begin
            if (byte_hit[i] && acc[i] == ACC_RW)
                hdr_d[i] = byte_val[i];
        end
        hdr_d[6] = sts_n[7:0];
        hdr_d[7] = sts_n[15:8];
        for (int j = 0; j < NUM_SLOTS; j++) begin
            if (bar_wr[j]) begin
                for (int k = 0; k < 4; k++)
                    hdr_d[6'(bar_base[j] + 6'(k))] = bar_val[j][8*k +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q   <= RST_IMG;
            remap_q <= 1'b0;
        end else begin
            hdr_q   <= hdr_d;
            remap_q <= byte_hit[4] | byte_hit[5];
        end
    end

    assign rd_data     = hdr_q[{rd_addr, 2'b00} +: 4];
    assign remap_pulse = remap_q;

endmodule

// File: rtl/cfg_hdr_chk.sv
module cfg_hdr_chk
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0]               VENDOR_ID    = 16'hA5C3,
    parameter logic [15:0]               DEVICE_ID    = 16'h7E21,
    parameter logic [7:0]                HDR_TYPE     = 8'h00,
    parameter logic [15:0]               STS_W1C_MASK = 16'hF900,
    parameter logic [15:0]               STS_FIXED    = 16'h0010,
    parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE     = '0,
    parameter logic [NUM_BARS-1:0]       BAR_IS_IO    = '0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [5:0]  wr_addr,
    input logic [1:0]  wr_size,
    input logic [15:0] status_set,
    input logic        remap_pulse,
    input hdr_img_t    hdr
);

    localparam logic ORD = !layout_is_bridge(HDR_TYPE);

    logic       past_ok;
    logic [2:0] cnt;
    logic       touch;
    logic [15:0] sts;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign cnt   = size_to_count(wr_size);
    assign touch = wr_en && (cnt != 3'd0) && ({1'b0, wr_addr} <= 7'd5) &&
                   (({1'b0, wr_addr} + {4'b0, cnt}) > 7'd4);
    assign sts   = {hdr[7], hdr[6]};

    assert_ident_R1: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ({hdr[3], hdr[2], hdr[1], hdr[0]} == {DEVICE_ID, VENDOR_ID}));

    assert_status_noset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((sts & ~$past(sts) & ~$past(status_set)) == 16'h0));

    assert_status_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((sts & ~STS_W1C_MASK) == (STS_FIXED & ~STS_W1C_MASK)));

    assert_remap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (remap_pulse == $past(touch)));

    for (genvar j = 0; j < NUM_BARS; j++) begin : g_bar
        if (ORD || j < BRIDGE_BARS) begin : g_live
            logic [31:0] dw;
            assign dw = {hdr[BAR_FIRST+4*j+3], hdr[BAR_FIRST+4*j+2],
                         hdr[BAR_FIRST+4*j+1], hdr[BAR_FIRST+4*j]};
            if (BAR_SIZE[j] == 32'h0) begin : g_none
                assert_bar_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
                    past_ok |-> (dw == 32'h0));
            end else if (BAR_IS_IO[j]) begin : g_io
                assert_bar_io_R7: assert property (@(posedge clk) disable iff (!rst_n)
                    past_ok |-> (dw[0] && ((dw & (BAR_SIZE[j] - 32'h1) & ~32'h1) == 32'h0)));
            end else begin : g_mem
                assert_bar_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
                    past_ok |-> ((dw & ((BAR_SIZE[j] - 32'h1) | 32'hF)) == 32'h0));
            end
        end
    end

endmodule

bind cfg_hdr_file cfg_hdr_chk #(
    .VENDOR_ID    (VENDOR_ID),
    .DEVICE_ID    (DEVICE_ID),
    .HDR_TYPE     (HDR_TYPE),
    .STS_W1C_MASK (STS_W1C_MASK),
    .STS_FIXED    (STS_FIXED),
    .BAR_SIZE     (BAR_SIZE),
    .BAR_IS_IO    (BAR_IS_IO)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_size     (wr_size),
    .status_set  (status_set),
    .remap_pulse (remap_pulse),
    .hdr         (hdr_q)
);

// File: tb/sim_cfg_hdr_file.sv
module sim_cfg_hdr_file;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NV         = 27;

    // {sel, addr[5:0], size[1:0], data[31:0], rd[3:0], expected[31:0], req[3:0]}
    localparam logic [80:0] VEC [NV] = '{
        {1'b0, 6'h00, 2'd2, 32'hFFFFFFFF, 4'd0,  32'h7E21A5C3, 4'd2},  // R2 identity
        {1'b0, 6'h04, 2'd1, 32'h00000007, 4'd1,  32'h00100007, 4'd4},  // R4 command word
        {1'b0, 6'h0C, 2'd2, 32'h12345678, 4'd3,  32'h12005678, 4'd2},  // R2 header type kept
        {1'b0, 6'h3C, 2'd0, 32'h0000000B, 4'd15, 32'h0000010B, 4'd4},  // R4 single byte
        {1'b0, 6'h3C, 2'd2, 32'hAABBCCDD, 4'd15, 32'hAABB01DD, 4'd2},  // R2 pin kept
        {1'b0, 6'h10, 2'd2, 32'hFFFFFFFF, 4'd4,  32'hFFFFFFE1, 4'd7},  // R7 I/O BAR
        {1'b0, 6'h14, 2'd2, 32'h12345FFF, 4'd5,  32'h12345000, 4'd7},  // R7 memory BAR
        {1'b0, 6'h14, 2'd1, 32'h0000FFFF, 4'd5,  32'h12345000, 4'd7},  // R7 partial ignored
        {1'b0, 6'h18, 2'd2, 32'hFFFFFFFF, 4'd6,  32'h00000000, 4'd8},  // R8 unimplemented
        {1'b0, 6'h30, 2'd2, 32'hABCDE7FF, 4'd12, 32'hABCDE001, 4'd9},  // R9 ROM enable set
        {1'b0, 6'h30, 2'd2, 32'h00012800, 4'd12, 32'h00012800, 4'd9},  // R9 ROM enable clear
        {1'b0, 6'h3E, 2'd2, 32'h11223344, 4'd15, 32'h334401DD, 4'd4},  // R4 past 0x3F dropped
        {1'b0, 6'h0F, 2'd3, 32'hFFFFFFFF, 4'd3,  32'h12005678, 4'd4},  // R4 size 3 no bytes
        {1'b0, 6'h28, 2'd2, 32'hCAFEF00D, 4'd10, 32'hCAFEF00D, 4'd2},  // R2 writable 0x28
        {1'b0, 6'h2C, 2'd2, 32'hFFFFFFFF, 4'd11, 32'h00000000, 4'd2},  // R2 subsystem kept
        {1'b0, 6'h07, 2'd0, 32'h000000FF, 4'd1,  32'h00100007, 4'd6},  // R6 fixed bit
        {1'b0, 6'h05, 2'd0, 32'h00000001, 4'd1,  32'h00100107, 4'd4},  // R4 command high
        {1'b1, 6'h10, 2'd2, 32'hFFFFFFFF, 4'd4,  32'hFFFFFF00, 4'd7},  // R7 bridge BAR0
        {1'b1, 6'h10, 2'd1, 32'h00000000, 4'd4,  32'hFFFFFF00, 4'd3},  // R3 BAR bytes kept
        {1'b1, 6'h18, 2'd2, 32'h01020304, 4'd6,  32'h01020304, 4'd3},  // R3 bus numbers
        {1'b1, 6'h2C, 2'd2, 32'hFFFFFFFF, 4'd11, 32'hFFFFFFFF, 4'd3},  // R3 writable 0x2C
        {1'b1, 6'h30, 2'd2, 32'hCAFE0001, 4'd12, 32'hCAFE0001, 4'd3},  // R3 writable 0x30
        {1'b1, 6'h38, 2'd2, 32'hFFFFFFFF, 4'd14, 32'hFFFFF001, 4'd9},  // R9 bridge ROM
        {1'b1, 6'h38, 2'd1, 32'h00000000, 4'd14, 32'hFFFFF001, 4'd3},  // R3 ROM bytes kept
        {1'b1, 6'h0E, 2'd0, 32'h00000000, 4'd3,  32'h00010000, 4'd3},  // R3 header type kept
        {1'b1, 6'h14, 2'd2, 32'hFFFFFFFF, 4'd5,  32'h00000000, 4'd8},  // R8 bridge BAR1
        {1'b1, 6'h00, 2'd2, 32'h00000000, 4'd0,  32'h7E21A5C3, 4'd3}   // R3 identity
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we0 = 1'b0;
    logic        we1 = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] status_set = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd0, rd1;
    logic        rp0, rp1;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_hdr_file u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(we0), .wr_addr(wr_addr), .wr_size(wr_size),
        .wr_data(wr_data), .status_set(status_set), .rd_addr(rd_addr),
        .rd_data(rd0), .remap_pulse(rp0)
    );

    cfg_hdr_file #(
        .HDR_TYPE  (8'h01),
        .BAR_SIZE  ({32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h100}),
        .BAR_IS_IO (6'b000000),
        .ROM_SIZE  (32'h1000)
    ) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(we1), .wr_addr(wr_addr), .wr_size(wr_size),
        .wr_data(wr_data), .status_set(status_set), .rd_addr(rd_addr),
        .rd_data(rd1), .remap_pulse(rp1)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic sel, input logic [5:0] a, input logic [1:0] s,
                            input logic [31:0] d);
        @(negedge clk);
        wr_addr = a; wr_size = s; wr_data = d;
        we0 = !sel; we1 = sel;
        @(negedge clk);
        we0 = 1'b0; we1 = 1'b0;
    endtask

    task automatic read_dw(input logic sel, input logic [3:0] idx, output logic [31:0] v);
        rd_addr = idx;
        #1;
        v = sel ? rd1 : rd0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset image
        read_dw(1'b0, 4'd0, v);  check("R1 id", v, 32'h7E21A5C3);
        read_dw(1'b0, 4'd1, v);  check("R1 cmd/status", v, 32'h00100000);
        read_dw(1'b0, 4'd2, v);  check("R1 class", v, 32'h02000004);
        read_dw(1'b0, 4'd4, v);  check("R1 io bar", v, 32'h00000001);
        read_dw(1'b0, 4'd15, v); check("R1 pin", v, 32'h00000100);
        read_dw(1'b1, 4'd3, v);  check("R1 bridge type", v, 32'h00010000);
        read_dw(1'b1, 4'd14, v); check("R1 bridge rom", v, 32'h00000000);
        check("R10 idle", {31'b0, rp0}, 32'h0);

        for (int n = 0; n < NV; n++) begin
            logic [80:0] e;
            string tag;
            e = VEC[n];
            do_write(e[80], e[79:74], e[73:72], e[71:40]);
            read_dw(e[80], e[39:36], v);
            tag = $sformatf("R%0d vec%0d", e[3:0], n);
            check(tag, v, e[35:4]);
        end

        // R5 set through events; only clearable bits take effect
        @(negedge clk);
        status_set = 16'hF9FF;
        @(negedge clk);
        status_set = 16'h0;
        read_dw(1'b0, 4'd1, v); check("R5 set", v, 32'hF9100107);
        do_write(1'b0, 6'h06, 2'd1, 32'h00000800);
        read_dw(1'b0, 4'd1, v); check("R5 clear bit11", v, 32'hF1100107);
        do_write(1'b0, 6'h07, 2'd0, 32'h00000080);
        read_dw(1'b0, 4'd1, v); check("R5 clear bit15", v, 32'h71100107);
        @(negedge clk);
        wr_addr = 6'h06; wr_size = 2'd1; wr_data = 32'h00004000;
        we0 = 1'b1; status_set = 16'h4000;
        @(negedge clk);
        we0 = 1'b0; status_set = 16'h0;
        read_dw(1'b0, 4'd1, v); check("R5 set wins", v, 32'h71100107);

        // R10 remap pulse
        do_write(1'b0, 6'h04, 2'd0, 32'h00000006);
        check("R10 pulse", {31'b0, rp0}, 32'h1);
        @(negedge clk);
        check("R10 one cycle", {31'b0, rp0}, 32'h0);
        do_write(1'b0, 6'h08, 2'd2, 32'hFFFFFFFF);
        check("R10 no touch", {31'b0, rp0}, 32'h0);
        do_write(1'b0, 6'h02, 2'd2, 32'h02030000);
        check("R10 spanning write", {31'b0, rp0}, 32'h1);
        read_dw(1'b0, 4'd1, v); check("R4 spanning data", v, 32'h71100203);
        read_dw(1'b0, 4'd0, v); check("R2 id after span", v, 32'h7E21A5C3);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule